// File: doc/BRIEF.md
# Pulsed-Request Wait-State Memory Responder

This block is a memory target for a processor core. Reads and writes arrive on two separate channels. Each channel has its own address bus and its own busy line. The core starts a transfer by raising a request line for exactly one clock cycle. The block samples the address, and for writes the data and a per-bit mask, in that cycle. Because the two channels are independent, one read and one write can be in flight at the same time, as with a dual-ported memory.

A parameter sets the number of wait states. At zero, the busy lines never rise and read data appears in the cycle after the request, so the block behaves as a zero-wait-state RAM. A nonzero setting holds the channel busy for that many cycles after each request. A request made while its channel is busy breaks the protocol. The block drops that request and sets a sticky error flag. The storage array is written so that a block RAM can be inferred. It reads old data when a read and a write hit the same word in the same cycle.

Top module: `wait_mem_target`

## Requirements
- R1: A write updates only the bits of the addressed word whose `wr_mask` bit is 1; bits with a mask bit of 0 keep their previous value.
- R2: An accepted read of a word returns the contents that word holds at the acceptance edge, as the last completed writes and masks define them.
- R3: With `LATENCY` = N > 0, the busy line of a channel is 1 in the N cycles that follow an accepted request and 0 after them; with N = 0 both busy lines stay 0.
- R4: `rd_data` is valid in the first cycle in which `rd_busy` is 0 after an accepted read, and it holds that value until the next accepted read.
- R5: When a read and a write to the same address are accepted in the same cycle, the read returns the word as it was before that write.
- R6: A read request made while `rd_busy` is 1 is dropped: `rd_data` keeps the result of the read in progress, and `proto_err` becomes 1 in the following cycle.
- R7: A write request made while `wr_busy` is 1 is dropped: the addressed word is unchanged, and `proto_err` becomes 1 in the following cycle.
- R8: Once set, `proto_err` stays 1 until reset.
- R9: Reset, which is synchronous and active high, clears both busy lines, the wait counters and `proto_err`. It leaves the stored words unchanged.
- R10: The read and write channels run independently: a read and a write to different addresses issued in the same cycle both complete after N wait cycles with their correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | One-cycle read request pulse |
| rd_addr | input | ADDR_W | Read word address, sampled with `rd_req` |
| rd_data | output | DATA_W | Read result |
| rd_busy | output | 1 | Read channel busy |
| wr_req | input | 1 | One-cycle write request pulse |
| wr_addr | input | ADDR_W | Write word address, sampled with `wr_req` |
| wr_data | input | DATA_W | Write data, sampled with `wr_req` |
| wr_mask | input | DATA_W | Per-bit write enable, sampled with `wr_req` |
| wr_busy | output | 1 | Write channel busy |
| proto_err | output | 1 | Sticky flag for a request made while busy |

## Verification
The assertions take for granted that addresses stay below `DEPTH` and that the request lines are known values after reset. They do not assume that the requester obeys the busy lines, because a broken handshake is behaviour the block must flag. The stimulus keeps addresses in range on a small configuration. It breaks the handshake only on purpose, in the R6 and R7 cases, and checks the error flag and the dropped transfer there. Every other request waits for the matching busy line to fall.

// File: rtl/wmt_pkg.sv
package wmt_pkg;
  // width of a counter that must hold values 0..max_val
  function automatic int unsigned count_width(input int unsigned max_val);
    int unsigned w;
    w = 1;
    while ((2 ** w) <= max_val) w++;
    return w;
  endfunction
endpackage

// File: rtl/wmt_busy_tracker.sv
module wmt_busy_tracker #(
  parameter int unsigned LATENCY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic accept,
  output logic violation,
  output logic busy
);
  import wmt_pkg::*;

  generate
    if (LATENCY == 0) begin : g_zero_wait
      assign busy      = 1'b0;
      assign accept    = req;
      assign violation = 1'b0;
    end else begin : g_wait
      localparam int unsigned CW = count_width(LATENCY);
      logic [CW-1:0] cnt_q;

      assign busy      = (cnt_q != '0);
      assign accept    = req && !busy;
      assign violation = req && busy;

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
        end else if (accept) begin
          cnt_q <= CW'(LATENCY);
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - CW'(1);
        end
      end

      assert_busy_after_accept_R3: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);
      assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(LATENCY));
      assert_busy_drop_needs_last_count_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt_q != CW'(1) && !accept) |=> busy);
    end
  endgenerate
endmodule

// File: rtl/wmt_masked_ram.sv
module wmt_masked_ram #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] wr_mask
);
  logic [DATA_W-1:0] mem [DEPTH];

  // read-first port: a same-cycle write is not seen by this read
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

  // bit-granular write enables
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[b]) mem[wr_addr][b] <= wr_data[b];
    end
  end
endmodule

// File: rtl/wmt_proto_monitor.sv
module wmt_proto_monitor (
  input  logic clk,
  input  logic rst,
  input  logic rd_violation,
  input  logic wr_violation,
  output logic err
);
  always_ff @(posedge clk) begin
    if (rst)                              err <= 1'b0;
    else if (rd_violation || wr_violation) err <= 1'b1;
  end

  assert_rd_violation_flags_R6: assert property (@(posedge clk) disable iff (rst)
    rd_violation |=> err);
  assert_wr_violation_flags_R7: assert property (@(posedge clk) disable iff (rst)
    wr_violation |=> err);
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

// File: rtl/wait_mem_target.sv
module wait_mem_target #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DEPTH   = 256,
  parameter int unsigned LATENCY = 2,
  localparam int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_busy,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] wr_mask,
  output logic              wr_busy,
  output logic              proto_err
);
  logic rd_acc, rd_viol, wr_acc, wr_viol;

  wmt_busy_tracker #(.LATENCY(LATENCY)) u_rd_track (
    .clk(clk), .rst(rst), .req(rd_req),
    .accept(rd_acc), .violation(rd_viol), .busy(rd_busy)
  );

  wmt_busy_tracker #(.LATENCY(LATENCY)) u_wr_track (
    .clk(clk), .rst(rst), .req(wr_req),
    .accept(wr_acc), .violation(wr_viol), .busy(wr_busy)
  );

  wmt_masked_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk),
    .rd_en(rd_acc), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_acc), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask)
  );

  wmt_proto_monitor u_mon (
    .clk(clk), .rst(rst),
    .rd_violation(rd_viol), .wr_violation(wr_viol), .err(proto_err)
  );

  assert_rd_data_held_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_acc |=> $stable(rd_data));
  assert_busy_known_R9: assert property (@(posedge clk)
    $past(rst) |-> (!rd_busy && !wr_busy && !proto_err));
endmodule

// File: tb/wait_mem_target_bench.sv
module wait_mem_target_bench;
  localparam int DW = 8;
  localparam int DP = 16;
  localparam int AW = 4;
  localparam int LAT = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst;
  logic rd_req, wr_req, rd_busy, wr_busy, perr;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] wr_data, wr_mask, rd_data;

  logic z_rd_req, z_wr_req, z_rd_busy, z_wr_busy, z_perr;
  logic [AW-1:0] z_rd_addr, z_wr_addr;
  logic [DW-1:0] z_wr_data, z_wr_mask, z_rd_data;

  wait_mem_target #(.DATA_W(DW), .DEPTH(DP), .LATENCY(LAT)) u_wait_mem_target (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_busy(rd_busy), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_mask(wr_mask), .wr_busy(wr_busy), .proto_err(perr)
  );

  wait_mem_target #(.DATA_W(DW), .DEPTH(DP), .LATENCY(0)) u_wait_mem_target_zero (
    .clk(clk), .rst(rst), .rd_req(z_rd_req), .rd_addr(z_rd_addr), .rd_data(z_rd_data),
    .rd_busy(z_rd_busy), .wr_req(z_wr_req), .wr_addr(z_wr_addr), .wr_data(z_wr_data),
    .wr_mask(z_wr_mask), .wr_busy(z_wr_busy), .proto_err(z_perr)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DW-1:0] model [DP];
  logic [DW-1:0] zmodel [DP];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic wr_op(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [DW-1:0] m);
    int n;
    @(negedge clk);
    wr_req = 1; wr_addr = a; wr_data = d; wr_mask = m;
    @(negedge clk);
    wr_req = 0;
    n = 0;
    while (wr_busy) begin @(negedge clk); n++; end
    check("R3 write busy length", n, LAT);
    model[a] = (model[a] & ~m) | (d & m);
  endtask

  task automatic rd_op(input logic [AW-1:0] a, input string req);
    int n;
    @(negedge clk);
    rd_req = 1; rd_addr = a;
    @(negedge clk);
    rd_req = 0;
    n = 0;
    while (rd_busy) begin @(negedge clk); n++; end
    check("R3 read busy length", n, LAT);
    check(req, rd_data, model[a]);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] old;
    rst = 1;
    rd_req = 0; wr_req = 0; rd_addr = '0; wr_addr = '0; wr_data = '0; wr_mask = '0;
    z_rd_req = 0; z_wr_req = 0; z_rd_addr = '0; z_wr_addr = '0; z_wr_data = '0; z_wr_mask = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R9 reset rd_busy", rd_busy, 0);
    check("R9 reset wr_busy", wr_busy, 0);
    check("R9 reset proto_err", perr, 0);

    // full-mask fill and read back (R2)
    for (int a = 0; a < DP; a++) begin
      model[a] = '0;
      wr_op(a[AW-1:0], DW'(a * 17 + 3), '1);
    end
    for (int a = 0; a < DP; a++) rd_op(a[AW-1:0], "R2 readback after fill");

    // masked writes across several mask patterns (R1)
    for (int p = 0; p < 3; p++)
      for (int a = 0; a < DP; a++)
        wr_op(a[AW-1:0], DW'(a * 91 + p * 45 + 7), DW'((a * 37 + p * 101) ^ (8'h5A << p)));
    for (int a = 0; a < DP; a++) rd_op(a[AW-1:0], "R1 masked write result");
    wr_op(4'd3, 8'hFF, 8'h00);
    rd_op(4'd3, "R1 zero mask leaves word");

    // concurrent read and write, different addresses (R10)
    for (int a = 0; a < DP; a++) begin
      int n;
      logic [AW-1:0] ra, wa;
      ra = a[AW-1:0]; wa = AW'(a + 5);
      old = model[ra];
      @(negedge clk);
      rd_req = 1; rd_addr = ra; wr_req = 1; wr_addr = wa; wr_data = DW'(a * 29 + 1); wr_mask = 8'hF0;
      @(negedge clk);
      rd_req = 0; wr_req = 0;
      n = 0;
      while (rd_busy || wr_busy) begin @(negedge clk); n++; end
      check("R10 concurrent busy length", n, LAT);
      check("R10 concurrent read data", rd_data, old);
      model[wa] = (model[wa] & 8'h0F) | (DW'(a * 29 + 1) & 8'hF0);
    end
    for (int a = 0; a < DP; a++) rd_op(a[AW-1:0], "R10 concurrent write result");

    // same address, same cycle: old contents (R5)
    for (int a = 0; a < 4; a++) begin
      old = model[a];
      @(negedge clk);
      rd_req = 1; rd_addr = a[AW-1:0]; wr_req = 1; wr_addr = a[AW-1:0]; wr_data = ~old; wr_mask = '1;
      @(negedge clk);
      rd_req = 0; wr_req = 0;
      while (rd_busy || wr_busy) @(negedge clk);
      check("R5 read-during-write old data", rd_data, old);
      model[a] = ~old;
      rd_op(a[AW-1:0], "R5 new data after write");
    end
    check("R8 no error before violation", perr, 0);

    // illegal read while busy (R6)
    @(negedge clk);
    rd_req = 1; rd_addr = 4'd6;
    @(negedge clk);
    rd_addr = 4'd9;  // second pulse while busy
    @(negedge clk);
    rd_req = 0;
    check("R6 error flag after illegal read", perr, 1);
    while (rd_busy) @(negedge clk);
    check("R6 dropped read keeps first result", rd_data, model[6]);

    // illegal write while busy (R7)
    @(negedge clk);
    wr_req = 1; wr_addr = 4'd10; wr_data = 8'h11; wr_mask = '1;
    @(negedge clk);
    wr_addr = 4'd11; wr_data = ~model[11];
    @(negedge clk);
    wr_req = 0;
    model[10] = 8'h11;
    while (wr_busy) @(negedge clk);
    rd_op(4'd11, "R7 dropped write leaves word");
    rd_op(4'd10, "R7 legal write completed");
    repeat (5) @(negedge clk);
    check("R8 error stays set", perr, 1);

    // reset mid-read clears busy and error, keeps memory (R9)
    @(negedge clk);
    rd_req = 1; rd_addr = 4'd2;
    @(negedge clk);
    rd_req = 0; rst = 1;
    @(negedge clk);
    rst = 0;
    check("R9 reset clears rd_busy", rd_busy, 0);
    check("R9 reset clears proto_err", perr, 0);
    for (int a = 0; a < DP; a++) rd_op(a[AW-1:0], "R9 memory kept over reset");

    // zero-wait instance: back-to-back writes and reads (R3, R4)
    for (int a = 0; a < DP; a++) begin
      @(negedge clk);
      z_wr_req = 1; z_wr_addr = a[AW-1:0]; z_wr_data = DW'(a * 53 + 9); z_wr_mask = '1;
      zmodel[a] = DW'(a * 53 + 9);
    end
    @(negedge clk);
    z_wr_req = 0;
    check("R3 zero wait never busy (write)", z_wr_busy, 0);
    for (int a = 0; a < DP; a++) begin
      @(negedge clk);
      z_wr_req = 1; z_wr_addr = a[AW-1:0]; z_wr_data = DW'(a * 11); z_wr_mask = 8'h3C;
      zmodel[a] = (zmodel[a] & 8'hC3) | (DW'(a * 11) & 8'h3C);
    end
    @(negedge clk);
    z_wr_req = 0;
    @(negedge clk);
    z_rd_req = 1; z_rd_addr = '0;
    for (int a = 1; a <= DP; a++) begin
      @(negedge clk);
      check("R3 zero wait never busy (read)", z_rd_busy, 0);
      check("R4 zero wait data next cycle", z_rd_data, zmodel[a-1]);
      if (a < DP) z_rd_addr = a[AW-1:0];
      else z_rd_req = 0;
    end
    @(negedge clk);
    check("R4 zero wait data held", z_rd_data, zmodel[DP-1]);
    check("R8 zero wait no error", z_perr, 0);
    finish_run();
  end
endmodule